// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After every reset this block copies a fixed number of configuration bytes from a 2 Kbit two-wire serial EEPROM into on-chip configuration registers. It shares one data pin and one clock pin with a host-controlled bit-bang path. Both pins are open-drain with external pull-ups, so the block only produces pull-low enables and reads the data line back through a synchroniser. The loader owns both pins from reset until it finishes. After that, the host's own pull-low requests pass straight through to the pins.

The loader starts by watching the idle data line. A board with no EEPROM straps that line low. When the loader sees it low, it raises a "no EEPROM" flag and finishes without generating any clock. Otherwise it sets the EEPROM's internal pointer to zero and reads the bytes in sequence. Each byte goes out on a register write port with a one-cycle strobe. If any header byte is not acknowledged, the loader issues STOP, raises the flag and finishes.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done`, `no_eeprom` and `cfg_we` are 0 and both pull-low enables are 0, whatever the host inputs are.
- R2: If the synchronised data line is low at the second quarter-bit tick after reset, `no_eeprom` and `done` go to 1 within 3*QTR_DIV+4 cycles, no write strobe occurs and the clock pin is never pulled low.
- R3: On a present EEPROM the bus carries START, 0xA0, 0x00, repeated START, 0xA1, the data bytes, and exactly one STOP. Bytes are sent MSB first, and a header bit of 1 means the data line is released.
- R4: The loader acknowledges every data byte except the last by pulling the data line low in the ninth clock. It leaves the line released (NACK) after the last byte.
- R5: Data byte k (received MSB first) is presented on `cfg_wdata` with `cfg_addr` = k and a `cfg_we` pulse exactly one cycle long, for k = 0 to NUM_BYTES-1 in increasing order.
- R6: If the EEPROM leaves the acknowledge bit released after any header byte, the loader issues STOP, sets `no_eeprom`, sets `done` and writes nothing.
- R7: `done` and `no_eeprom` hold their values until the next reset. `no_eeprom` stays 0 after a successful load, and no write strobe follows `done`.
- R8: While the loader owns the clock pin, every high phase of the clock lasts exactly 2*QTR_DIV system cycles.
- R9: Once `done` is 1, `sda_oe` and `scl_oe` equal `host_sda_oe` and `host_scl_oe`. Before that, the host inputs have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a new load when released |
| sda_in | input | 1 | Level of the open-drain data pin (asynchronous) |
| host_sda_oe | input | 1 | Host bit-bang request to pull the data pin low |
| host_scl_oe | input | 1 | Host bit-bang request to pull the clock pin low |
| sda_oe | output | 1 | Pull-low enable for the data pin |
| scl_oe | output | 1 | Pull-low enable for the clock pin |
| cfg_we | output | 1 | One-cycle write strobe to the configuration registers |
| cfg_addr | output | ADDR_W | Configuration register index |
| cfg_wdata | output | 8 | Configuration byte |
| done | output | 1 | Load finished or abandoned; pins belong to the host |
| no_eeprom | output | 1 | No EEPROM detected (strapped line or missing acknowledge) |

## Verification
The properties assume a device that follows the two-wire protocol: it changes the data line only while the clock is low, and it answers only the device address 0xA0/0xA1. They also assume that reset is the only way to start a new load. The bench keeps to these assumptions with an EEPROM model that updates its output only on falling clock edges and decodes the control byte exactly. A missing device is modelled either by a strap held from before reset or by a model that withholds the acknowledge. Host pull-low requests are driven during the load to show that they are ignored there. They are also toggled after `done` to exercise the pin hand-over.

// File: rtl/cfgld_pkg.sv
// Package: shared operation codes, sequencer states and bus constants for
// the EEPROM configuration loader. Assumes a device strapped to address 0.
package cfgld_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRBIT = 2'd2,
        OP_RDBIT = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_PROBE  = 4'd0,
        ST_START1 = 4'd1,
        ST_CTRLW  = 4'd2,
        ST_WADDR  = 4'd3,
        ST_START2 = 4'd4,
        ST_CTRLR  = 4'd5,
        ST_RDATA  = 4'd6,
        ST_MACK   = 4'd7,
        ST_STOP   = 4'd8,
        ST_FINISH = 4'd9
    } seq_state_e;

    localparam logic [7:0] DEV_WR     = 8'hA0;
    localparam logic [7:0] DEV_RD     = 8'hA1;
    localparam logic [7:0] WORD_ADDR0 = 8'h00;

endpackage

// File: rtl/cfgld_tick.sv
// Quarter-bit tick generator. It emits a one-cycle pulse every QTR_DIV
// system cycles. Assumes QTR_DIV >= 1.
module cfgld_tick #(
    parameter int QTR_DIV = 4,
    localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [CW-1:0] cnt;

    // Free-running divider with a pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(QTR_DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgld_sync.sv
// Multi-stage synchroniser for the asynchronous data pin. It resets to the
// idle-high level of a pulled-up line. Assumes STAGES >= 2.
module cfgld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgld_bitphy.sv
// Bit-level two-wire engine. It runs one operation (START, STOP, write bit,
// read bit) over four quarter-bit ticks and produces open-drain pull-low
// enables. The read bit is sampled in the middle of the clock-high phase.
// Assumes the caller issues 'go' only while 'busy' is low.
module cfgld_bitphy
    import cfgld_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    go,
    input  bus_op_e op,
    input  logic    wbit,
    input  logic    sda_in,
    output logic    busy,
    output logic    op_done,
    output logic    rbit,
    output logic    sda_low,
    output logic    scl_low
);
    bus_op_e    cur_op;
    logic       cur_bit;
    logic [1:0] phase;

    // Accept an operation, then step its four phases on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            op_done <= 1'b0;
            rbit    <= 1'b1;
            sda_low <= 1'b0;
            scl_low <= 1'b0;
            cur_op  <= OP_START;
            cur_bit <= 1'b1;
            phase   <= 2'd0;
        end else begin
            op_done <= 1'b0;
            if (go && !busy) begin
                busy    <= 1'b1;
                cur_op  <= op;
                cur_bit <= wbit;
                phase   <= 2'd0;
            end else if (busy && tick) begin
                phase <= phase + 2'd1;
                case (cur_op)
                    OP_START: begin
                        case (phase)
                            2'd0:    sda_low <= 1'b0;
                            2'd1:    scl_low <= 1'b0;
                            2'd2:    sda_low <= 1'b1;
                            default: scl_low <= 1'b1;
                        endcase
                    end
                    OP_STOP: begin
                        case (phase)
                            2'd0: begin
                                scl_low <= 1'b1;
                                sda_low <= 1'b1;
                            end
                            2'd1:    scl_low <= 1'b0;
                            2'd2:    sda_low <= 1'b0;
                            default: ;
                        endcase
                    end
                    OP_WRBIT: begin
                        case (phase)
                            2'd0: begin
                                scl_low <= 1'b1;
                                sda_low <= ~cur_bit;
                            end
                            2'd1:    scl_low <= 1'b0;
                            2'd2:    rbit    <= sda_in;
                            default: scl_low <= 1'b1;
                        endcase
                    end
                    default: begin
                        case (phase)
                            2'd0: begin
                                scl_low <= 1'b1;
                                sda_low <= 1'b0;
                            end
                            2'd1:    scl_low <= 1'b0;
                            2'd2:    rbit    <= sda_in;
                            default: scl_low <= 1'b1;
                        endcase
                    end
                endcase
                if (phase == 2'd3) begin
                    busy    <= 1'b0;
                    op_done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgld_seq.sv
// Load sequencer. It probes for a strapped-low data line, sends the
// address header, reads NUM_BYTES bytes with ACK/NACK, writes each byte to
// the configuration port and finishes with STOP. A NACK on any header byte
// abandons the load. Assumes the bit engine answers every 'go' with one
// 'op_done'.
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sda_in,
    input  logic              op_done,
    input  logic              rbit,
    output logic              go,
    output bus_op_e           op,
    output logic              wbit,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [7:0]        cfg_wdata,
    output logic              done,
    output logic              no_eeprom
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_BYTES - 1);

    seq_state_e        state;
    logic              waiting;
    logic              probe_armed;
    logic [3:0]        bit_idx;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] byte_idx;
    logic              iss_en;
    bus_op_e           iss_op;
    logic              iss_bit;
    logic              last_byte;

    assign last_byte = (byte_idx == LAST_IDX);
    assign done      = (state == ST_FINISH);

    // Choose the bus operation that the current state needs next.
    always_comb begin
        iss_en  = 1'b0;
        iss_op  = OP_RDBIT;
        iss_bit = 1'b1;
        case (state)
            ST_START1, ST_START2: begin
                iss_en = 1'b1;
                iss_op = OP_START;
            end
            ST_STOP: begin
                iss_en = 1'b1;
                iss_op = OP_STOP;
            end
            ST_CTRLW, ST_WADDR, ST_CTRLR: begin
                iss_en = 1'b1;
                if (bit_idx < 4'd8) begin
                    iss_op  = OP_WRBIT;
                    iss_bit = shreg[7];
                end
            end
            ST_RDATA: iss_en = 1'b1;
            ST_MACK: begin
                iss_en  = 1'b1;
                iss_op  = OP_WRBIT;
                iss_bit = last_byte;
            end
            default: ;
        endcase
    end

    // Issue operations and advance the load on their completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_PROBE;
            waiting     <= 1'b0;
            probe_armed <= 1'b0;
            bit_idx     <= 4'd0;
            shreg       <= '0;
            byte_idx    <= '0;
            go          <= 1'b0;
            op          <= OP_START;
            wbit        <= 1'b1;
            cfg_we      <= 1'b0;
            cfg_addr    <= '0;
            cfg_wdata   <= '0;
            no_eeprom   <= 1'b0;
        end else begin
            go     <= 1'b0;
            cfg_we <= 1'b0;
            if (state == ST_PROBE) begin
                if (tick) begin
                    if (!probe_armed) begin
                        probe_armed <= 1'b1;
                    end else if (!sda_in) begin
                        no_eeprom <= 1'b1;
                        state     <= ST_FINISH;
                    end else begin
                        state <= ST_START1;
                    end
                end
            end else if (iss_en && !waiting) begin
                go      <= 1'b1;
                op      <= iss_op;
                wbit    <= iss_bit;
                waiting <= 1'b1;
            end else if (iss_en && op_done) begin
                waiting <= 1'b0;
                case (state)
                    ST_START1: begin
                        shreg   <= DEV_WR;
                        bit_idx <= 4'd0;
                        state   <= ST_CTRLW;
                    end
                    ST_START2: begin
                        shreg   <= DEV_RD;
                        bit_idx <= 4'd0;
                        state   <= ST_CTRLR;
                    end
                    ST_CTRLW, ST_WADDR, ST_CTRLR: begin
                        if (bit_idx < 4'd8) begin
                            shreg   <= {shreg[6:0], 1'b0};
                            bit_idx <= bit_idx + 4'd1;
                        end else begin
                            bit_idx <= 4'd0;
                            if (rbit) begin
                                no_eeprom <= 1'b1;
                                state     <= ST_STOP;
                            end else if (state == ST_CTRLW) begin
                                shreg <= WORD_ADDR0;
                                state <= ST_WADDR;
                            end else if (state == ST_WADDR) begin
                                state <= ST_START2;
                            end else begin
                                state <= ST_RDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        shreg <= {shreg[6:0], rbit};
                        if (bit_idx == 4'd7) begin
                            bit_idx   <= 4'd0;
                            cfg_we    <= 1'b1;
                            cfg_addr  <= byte_idx;
                            cfg_wdata <= {shreg[6:0], rbit};
                            state     <= ST_MACK;
                        end else begin
                            bit_idx <= bit_idx + 4'd1;
                        end
                    end
                    ST_MACK: begin
                        if (last_byte) begin
                            state <= ST_STOP;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= ST_RDATA;
                        end
                    end
                    ST_STOP: state <= ST_FINISH;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eeprom_cfg_loader.sv
// Top of the EEPROM configuration loader. It ties together the tick
// divider, the pin synchroniser, the bit engine and the sequencer, and
// hands the two open-drain pins to the host once the load is over.
// Assumes external pull-ups, NUM_BYTES >= 2, QTR_DIV >= 3, SYNC_STAGES >= 2.
module eeprom_cfg_loader #(
    parameter int NUM_BYTES   = 8,
    parameter int QTR_DIV     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_in,
    input  logic              host_sda_oe,
    input  logic              host_scl_oe,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [7:0]        cfg_wdata,
    output logic              done,
    output logic              no_eeprom
);
    import cfgld_pkg::*;

    logic    tick;
    logic    sda_s;
    logic    go;
    bus_op_e op;
    logic    wbit;
    logic    busy;
    logic    op_done;
    logic    rbit;
    logic    ldr_sda_low;
    logic    ldr_scl_low;

    cfgld_tick #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    cfgld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sda_in),
        .q    (sda_s)
    );

    cfgld_bitphy u_phy (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .go     (go),
        .op     (op),
        .wbit   (wbit),
        .sda_in (sda_s),
        .busy   (busy),
        .op_done(op_done),
        .rbit   (rbit),
        .sda_low(ldr_sda_low),
        .scl_low(ldr_scl_low)
    );

    cfgld_seq #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sda_in   (sda_s),
        .op_done  (op_done),
        .rbit     (rbit),
        .go       (go),
        .op       (op),
        .wbit     (wbit),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .done     (done),
        .no_eeprom(no_eeprom)
    );

    // Pin ownership: the loader until done, then the host bit-bang path.
    assign sda_oe = done ? host_sda_oe : ldr_sda_low;
    assign scl_oe = done ? host_scl_oe : ldr_scl_low;

    logic unused_busy;
    assign unused_busy = busy;
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
// Checker for the EEPROM configuration loader, bound to the top module.
// Assumes a single synchronous active-low reset restarts every load.
module eeprom_cfg_loader_chk #(
    parameter int NUM_BYTES = 8,
    parameter int ADDR_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_oe,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              done,
    input logic              no_eeprom
);
    int unsigned we_cnt;

    // Count write strobes since reset to predict the next address.
    always_ff @(posedge clk) begin
        if (!rst_n)      we_cnt <= 0;
        else if (cfg_we) we_cnt <= we_cnt + 1;
    end

    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_we);

    p_addr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (cfg_addr == ADDR_W'(we_cnt)) && (we_cnt < NUM_BYTES));

    p_done_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_flag_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_eeprom |=> no_eeprom);

    p_no_write_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cfg_we);

    p_abort_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        no_eeprom |-> !cfg_we);

    p_released_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe && !scl_oe && !done);
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk #(
    .NUM_BYTES(NUM_BYTES),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .done     (done),
    .no_eeprom(no_eeprom)
);

// File: tb/eeprom_cfg_loader_tb.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_tb;
    localparam int NB = 8;
    localparam int QD = 4;
    localparam int AW = $clog2(NB);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic host_sda_oe = 1'b0;
    logic host_scl_oe = 1'b0;
    logic strap_low = 1'b0;
    logic nack_ctrl = 1'b0;
    logic slave_low = 1'b0;

    logic          sda_oe, scl_oe, cfg_we, done, no_eeprom;
    logic [AW-1:0] cfg_addr;
    logic [7:0]    cfg_wdata;

    wire sda_line = !(sda_oe | slave_low | strap_low);
    wire scl_line = !scl_oe;

    eeprom_cfg_loader #(.NUM_BYTES(NB), .QTR_DIV(QD)) u_dut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_line),
        .host_sda_oe(host_sda_oe), .host_scl_oe(host_scl_oe),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .done(done), .no_eeprom(no_eeprom)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input int seed, input int a);
        return 8'((a * 53 + seed * 29 + 7) ^ (a << 4));
    endfunction

    // ---------------- EEPROM model ----------------
    int mem_seed = 1;
    int mode = 0;          // 0 idle, 1 receiving, 2 transmitting
    int bitn = 0;
    int kind = 0;          // 0 control, 1 word address, 2 other
    int ack_ph = 0;
    int stop_cnt = 0;
    logic [7:0] m_sh = 0;
    logic [7:0] ptr = 0;
    logic [7:0] cur = 0;
    logic will_ack = 0, rw = 0, m_ack = 1;
    logic [7:0] seen_hdr[$];
    logic       seen_macks[$];

    always @(negedge sda_line) if (scl_line === 1'b1 && rst_n) begin
        mode = 1; bitn = 0; kind = 0; ack_ph = 0; slave_low = 0;
    end

    always @(posedge sda_line) if (scl_line === 1'b1 && rst_n) begin
        mode = 0; slave_low = 0; stop_cnt++;
    end

    always @(posedge scl_line) if (rst_n) begin
        if (mode == 1 && ack_ph == 0) begin
            m_sh = {m_sh[6:0], sda_line};
            bitn++;
            if (bitn == 8) begin
                seen_hdr.push_back(m_sh);
                if (kind == 0) begin
                    will_ack = !nack_ctrl && (m_sh[7:1] == 7'h50);
                    rw = m_sh[0];
                end else begin
                    if (kind == 1) ptr = m_sh;
                    will_ack = 1;
                end
                ack_ph = 1;
            end
        end else if (mode == 2 && ack_ph == 0) begin
            bitn++;
            if (bitn == 8) ack_ph = 1;
        end else if (mode == 2 && ack_ph == 2) begin
            m_ack = sda_line;
            seen_macks.push_back(sda_line);
        end
    end

    always @(negedge scl_line) if (rst_n && mode != 0) begin
        if (ack_ph == 1) begin
            slave_low = (mode == 1) ? will_ack : 1'b0;
            ack_ph = 2;
        end else if (ack_ph == 2) begin
            ack_ph = 0; bitn = 0;
            if (mode == 1) begin
                slave_low = 0;
                if (!will_ack) mode = 0;
                else if (kind == 0 && rw) begin
                    mode = 2; cur = mem_byte(mem_seed, int'(ptr)); slave_low = !cur[7];
                end else if (kind == 0) kind = 1;
                else kind = 2;
            end else if (m_ack == 1'b0) begin
                ptr++; cur = mem_byte(mem_seed, int'(ptr)); slave_low = !cur[7];
            end else begin
                mode = 0; slave_low = 0;
            end
        end else if (mode == 2 && bitn < 8) begin
            cur = mem_byte(mem_seed, int'(ptr));
            slave_low = !cur[7 - bitn];
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic [AW-1:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];

    task automatic push_load(input int seed);
        for (int i = 0; i < NB; i++) exp_q.push_back('{AW'(i), mem_byte(seed, i)});
    endtask

    // Monitor: compare each configuration write with the queued expectation (R5).
    always @(negedge clk) if (rst_n && cfg_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R5/R6 unexpected write", cfg_addr, 0);
        else begin
            wr_t e;
            e = exp_q.pop_front();
            chk(cfg_addr == e.a, "R5 addr", cfg_addr, e.a);
            chk(cfg_wdata == e.d, "R5 data", cfg_wdata, e.d);
        end
    end

    // Clock high-phase width monitor (R8) and clock-activity counter (R2).
    int hi_cnt = 0;
    bit seen_low = 0;
    int scl_low_cycles = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_cnt = 0; seen_low = 0;
        end else if (!done) begin
            if (scl_oe) begin
                scl_low_cycles++;
                if (seen_low && hi_cnt > 0) chk(hi_cnt == 2 * QD, "R8 scl high width", hi_cnt, 2 * QD);
                seen_low = 1; hi_cnt = 0;
            end else hi_cnt++;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        mode = 0; slave_low = 0; stop_cnt = 0; ack_ph = 0;
        seen_hdr.delete(); seen_macks.delete(); exp_q.delete();
        scl_low_cycles = 0;
        @(negedge clk);
        chk(!done && !no_eeprom && !cfg_we && !sda_oe && !scl_oe, "R1 state in reset",
            {done, no_eeprom, cfg_we, sda_oe, scl_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !no_eeprom && !sda_oe && !scl_oe, "R1 state after release",
            {done, no_eeprom, sda_oe, scl_oe}, 0);
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (!done && cycles < 20000) begin
            @(negedge clk);
            cycles++;
        end
        chk(done, "R7 done reached", done, 1);
    endtask

    task automatic check_good_load(input string tag);
        chk(no_eeprom == 1'b0, "R7 no flag after good load", no_eeprom, 0);
        chk(exp_q.size() == 0, "R5 all bytes written", exp_q.size(), 0);
        chk(seen_hdr.size() == 3, "R3 header count", seen_hdr.size(), 3);
        if (seen_hdr.size() == 3) begin
            chk(seen_hdr[0] == 8'hA0, "R3 control write", seen_hdr[0], 8'hA0);
            chk(seen_hdr[1] == 8'h00, "R3 word address", seen_hdr[1], 8'h00);
            chk(seen_hdr[2] == 8'hA1, "R3 control read", seen_hdr[2], 8'hA1);
        end
        chk(stop_cnt == 1, "R3 single STOP", stop_cnt, 1);
        chk(seen_macks.size() == NB, "R4 ack count", seen_macks.size(), NB);
        for (int i = 0; i < seen_macks.size(); i++)
            chk(seen_macks[i] == (i == NB - 1), "R4 ack/nack bit", seen_macks[i], (i == NB - 1));
        $display("%s load checked", tag);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #1ms;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        // Scenario 1: normal load, host requests active and ignored (R9).
        mem_seed = 1; host_sda_oe = 1; host_scl_oe = 1;
        push_load(1);
        do_reset();
        push_load(1);
        wait_done(cyc);
        check_good_load("seed1");
        host_sda_oe = 0; host_scl_oe = 0;
        @(negedge clk);
        chk(!sda_oe && !scl_oe, "R9 host release passes", {sda_oe, scl_oe}, 0);
        host_sda_oe = 1;
        @(negedge clk);
        chk(sda_oe && !scl_oe, "R9 host data pull", {sda_oe, scl_oe}, 2'b10);
        host_sda_oe = 0; host_scl_oe = 1;
        @(negedge clk);
        chk(!sda_oe && scl_oe, "R9 host clock pull", {sda_oe, scl_oe}, 2'b01);
        host_scl_oe = 0;
        repeat (100) @(negedge clk);
        chk(done && !no_eeprom, "R7 status held", {done, no_eeprom}, 2'b10);

        // Scenario 2: different contents.
        mem_seed = 77;
        do_reset();
        push_load(77);
        wait_done(cyc);
        check_good_load("seed77");

        // Scenario 3: data line strapped low (R2).
        strap_low = 1;
        do_reset();
        wait_done(cyc);
        chk(no_eeprom, "R2 flag on strap", no_eeprom, 1);
        chk(cyc <= 3 * QD + 4, "R2 early finish", cyc, 3 * QD + 4);
        chk(scl_low_cycles == 0, "R2 no clock generated", scl_low_cycles, 0);
        repeat (50) @(negedge clk);
        chk(exp_q.size() == 0 && no_eeprom && done, "R2 R7 no load, flag held", no_eeprom, 1);
        strap_low = 0;
        @(negedge clk);

        // Scenario 4: device does not acknowledge the control byte (R6).
        nack_ctrl = 1;
        do_reset();
        wait_done(cyc);
        chk(no_eeprom, "R6 flag on NACK", no_eeprom, 1);
        chk(seen_hdr.size() == 1, "R6 only control byte sent", seen_hdr.size(), 1);
        chk(stop_cnt == 1, "R6 STOP issued", stop_cnt, 1);
        chk(seen_macks.size() == 0, "R6 no data read", seen_macks.size(), 0);
        nack_ctrl = 0;

        // Scenario 5: recovery with a new reset.
        mem_seed = 5;
        do_reset();
        push_load(5);
        wait_done(cyc);
        check_good_load("seed5");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule